// File: doc/BRIEF.md
# Transmit Descriptor Format Guard

This block watches transmit buffer descriptors as the DMA engine fetches them, one descriptor per cycle on a valid strobe. It applies a fixed set of format rules to each descriptor. When a descriptor breaks one of them, the block latches a 3-bit error code and raises a host error interrupt. That error is sticky: only a module reset removes it.

One cycle after the error is latched, the block raises a halt request to the DMA engine. The halt request also stays high until reset. A small register port holds an interrupt enable bit that software sets and clears through separate write-one registers. The same port reads back the unmasked status, the masked status and the enable bit.

Packet structure is tracked across descriptors. A packet opens on a start-of-packet descriptor and closes on an end-of-packet descriptor. The buffer lengths between the two are summed and compared against the packet length carried by the opening descriptor.

Top module: `txdesc_guard`

## Requirements
- R1: After reset, errCode is 0, intRaw, intMasked and haltReq are low, and the interrupt enable bit reads 0.
- R2: Code 1 (framing) is flagged for a valid descriptor without the start flag while no packet is open, and for a descriptor with the start flag while a packet is open.
- R3: Code 2 (ownership) is flagged for a start-flagged descriptor whose ownership flag is 0.
- R4: Code 3 (broken chain) is flagged for a descriptor that lacks the end flag and has a next pointer of 0.
- R5: Code 4 (null buffer) is flagged for a buffer pointer of 0.
- R6: Code 5 (empty buffer) is flagged for a buffer length of 0.
- R7: Code 6 (length mismatch) is flagged on an end-flagged descriptor when the sum of buffer lengths from the opening descriptor through this one differs from the packet length field of the opening descriptor.
- R8: If one descriptor breaks several rules, the smallest code is latched. A cycle with descValid low never changes errCode.
- R9: Only the first error is latched. Later errors leave errCode unchanged until reset.
- R10: errCode and intRaw take their new value in the cycle after the clock edge that samples the faulty descriptor. haltReq rises one cycle after that and stays high until reset.
- R11: Writing a value with bit 0 set to address 2 sets the enable bit. Writing a value with bit 0 set to address 3 clears it. Writes with bit 0 clear have no effect. intMasked equals intRaw AND the enable bit.
- R12: regRdData returns the raw status at address 0, the masked status at address 1, and the enable bit at addresses 2 and 3. Each value sits in bit 0, and the upper bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low module reset |
| descValid | input | 1 | A descriptor is presented this cycle |
| descSop | input | 1 | Start-of-packet flag |
| descEop | input | 1 | End-of-packet flag |
| descOwn | input | 1 | Ownership flag |
| descNext | input | AW | Next descriptor pointer |
| descBufPtr | input | AW | Buffer pointer |
| descBufLen | input | LW | Buffer length |
| descPktLen | input | LW | Packet length, used from the start-flagged descriptor |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | DW | Register write data |
| regRdData | output | DW | Register read data, combinational on regAddr |
| errCode | output | 3 | Latched first error code, 0 means no error |
| intRaw | output | 1 | Unmasked host error interrupt |
| intMasked | output | 1 | Masked host error interrupt |
| haltReq | output | 1 | Halt request to the DMA engine |

## Verification
The assertions assume that rstN is held low across at least one clock edge, so every register starts from its reset value. They also assume that descValid and the register strobe are driven to known values on every cycle. The stimulus drives all inputs only at the falling edge and parks descValid and regWrEn low between operations. The random packets keep buffer lengths small, so the length accumulator never wraps and the bench's unbounded sum stays a valid reference.

// File: rtl/txdg_pkg.sv
package txdg_pkg;

  typedef enum logic [2:0] {
    ERR_NONE = 3'd0,
    ERR_SOP  = 3'd1,
    ERR_OWN  = 3'd2,
    ERR_NEXT = 3'd3,
    ERR_PTR  = 3'd4,
    ERR_LEN  = 3'd5,
    ERR_PKT  = 3'd6
  } errCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startPkt;
    logic addLen;
  } dpStrobe_t;

  // rule results from datapath to control
  typedef struct packed {
    logic ownBad;
    logic nextBad;
    logic ptrBad;
    logic lenBad;
    logic pktBad;
  } ruleHits_t;

  localparam logic [1:0] ADDR_RAW = 2'd0;
  localparam logic [1:0] ADDR_MSK = 2'd1;
  localparam logic [1:0] ADDR_SET = 2'd2;
  localparam logic [1:0] ADDR_CLR = 2'd3;

endpackage

// File: rtl/txdg_datapath.sv
module txdg_datapath
  import txdg_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int GUARD = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic          descSop,
  input  logic          descEop,
  input  logic          descOwn,
  input  logic [AW-1:0] descNext,
  input  logic [AW-1:0] descBufPtr,
  input  logic [LW-1:0] descBufLen,
  input  logic [LW-1:0] descPktLen,
  output ruleHits_t     hits
);

  localparam int ACCW = LW + GUARD;

  logic [ACCW-1:0] accLen;
  logic [LW-1:0]   pktRef;
  logic [ACCW-1:0] sumNow;
  logic [ACCW-1:0] refNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accLen <= '0;
      pktRef <= '0;
    end else if (strobe.startPkt) begin
      accLen <= ACCW'(descBufLen);
      pktRef <= descPktLen;
    end else if (strobe.addLen) begin
      accLen <= accLen + ACCW'(descBufLen);
    end
  end

  always_comb begin
    sumNow = descSop ? ACCW'(descBufLen) : accLen + ACCW'(descBufLen);
    refNow = descSop ? ACCW'(descPktLen) : ACCW'(pktRef);
    hits.ownBad  = descSop && !descOwn;
    hits.nextBad = !descEop && (descNext == '0);
    hits.ptrBad  = (descBufPtr == '0);
    hits.lenBad  = (descBufLen == '0);
    hits.pktBad  = descEop && (sumNow != refNow);
  end

  // a started packet carries the length of its opening buffer (R7)
  assert_acc_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startPkt |=> (accLen == ACCW'($past(descBufLen))));

endmodule

// File: rtl/txdg_control.sv
module txdg_control
  import txdg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          descValid,
  input  logic          descSop,
  input  logic          descEop,
  input  ruleHits_t     hits,
  input  logic          regWrEn,
  input  logic [1:0]    regAddr,
  input  logic [DW-1:0] regWrData,
  output dpStrobe_t     strobe,
  output logic [DW-1:0] regRdData,
  output logic [2:0]    errCode,
  output logic          intRaw,
  output logic          intMasked,
  output logic          haltReq
);

  logic     inPkt;
  logic     maskEn;
  logic     haltQ;
  errCode_e codeQ;
  errCode_e firstCode;
  logic     sopBad;

  assign sopBad = (descSop == inPkt);

  always_comb begin
    if (sopBad)            firstCode = ERR_SOP;
    else if (hits.ownBad)  firstCode = ERR_OWN;
    else if (hits.nextBad) firstCode = ERR_NEXT;
    else if (hits.ptrBad)  firstCode = ERR_PTR;
    else if (hits.lenBad)  firstCode = ERR_LEN;
    else if (hits.pktBad)  firstCode = ERR_PKT;
    else                   firstCode = ERR_NONE;
  end

  always_comb begin
    strobe.startPkt = descValid && descSop;
    strobe.addLen   = descValid && !descSop && inPkt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPkt  <= 1'b0;
      codeQ  <= ERR_NONE;
      haltQ  <= 1'b0;
      maskEn <= 1'b0;
    end else begin
      if (descValid) inPkt <= (descSop || inPkt) && !descEop;
      if (descValid && codeQ == ERR_NONE) codeQ <= firstCode;
      haltQ <= haltQ || (codeQ != ERR_NONE);
      if (regWrEn && regWrData[0]) begin
        if (regAddr == ADDR_SET)      maskEn <= 1'b1;
        else if (regAddr == ADDR_CLR) maskEn <= 1'b0;
      end
    end
  end

  assign errCode   = codeQ;
  assign intRaw    = (codeQ != ERR_NONE);
  assign intMasked = intRaw && maskEn;
  assign haltReq   = haltQ;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_RAW: regRdData[0] = intRaw;
      ADDR_MSK: regRdData[0] = intMasked;
      default:  regRdData[0] = maskEn;
    endcase
  end

  assert_code_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (errCode != 3'd0) |=> $stable(errCode));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!descValid && errCode == 3'd0) |=> (errCode == 3'd0));
  assert_code_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    errCode <= 3'd6);
  assert_halt_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    intRaw |=> haltReq);
  assert_halt_not_early_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!intRaw && !haltReq) |=> !haltReq);
  assert_mask_set_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_SET && regWrData[0]) |=> maskEn);
  assert_mask_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_CLR && regWrData[0]) |=> !maskEn);

endmodule

// File: rtl/txdesc_guard.sv
module txdesc_guard
  import txdg_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          descValid,
  input  logic          descSop,
  input  logic          descEop,
  input  logic          descOwn,
  input  logic [AW-1:0] descNext,
  input  logic [AW-1:0] descBufPtr,
  input  logic [LW-1:0] descBufLen,
  input  logic [LW-1:0] descPktLen,
  input  logic          regWrEn,
  input  logic [1:0]    regAddr,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  output logic [2:0]    errCode,
  output logic          intRaw,
  output logic          intMasked,
  output logic          haltReq
);

  dpStrobe_t strobe;
  ruleHits_t hits;

  txdg_datapath #(.AW(AW), .LW(LW)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .descSop(descSop), .descEop(descEop), .descOwn(descOwn),
    .descNext(descNext), .descBufPtr(descBufPtr),
    .descBufLen(descBufLen), .descPktLen(descPktLen),
    .hits(hits)
  );

  txdg_control #(.DW(DW)) ctl (
    .clk(clk), .rstN(rstN), .descValid(descValid),
    .descSop(descSop), .descEop(descEop), .hits(hits),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .strobe(strobe), .regRdData(regRdData), .errCode(errCode),
    .intRaw(intRaw), .intMasked(intMasked), .haltReq(haltReq)
  );

  assert_masked_implies_raw_R11: assert property (@(posedge clk) disable iff (!rstN)
    intMasked |-> intRaw);
  assert_raw_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    intRaw |=> intRaw);

endmodule

// File: tb/txdesc_guard_test.sv
module txdesc_guard_test;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, descValid, descSop, descEop, descOwn, regWrEn;
  logic [AW-1:0] descNext, descBufPtr;
  logic [LW-1:0] descBufLen, descPktLen;
  logic [1:0]    regAddr;
  logic [DW-1:0] regWrData, regRdData;
  logic [2:0]    errCode;
  logic intRaw, intMasked, haltReq;

  txdesc_guard #(.AW(AW), .LW(LW), .DW(DW)) uut (.*);

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  int mCode, mInPkt, mAcc, mRef;
  bit mHalt, mMask;

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int refCode(int inPkt, int acc, int pref, bit s, bit e, bit o,
                                 int nxt, int ptr, int len, int pkt);
    int sum, r;
    if (inPkt == int'(s)) return 1;
    if (s && !o) return 2;
    if (!e && nxt == 0) return 3;
    if (ptr == 0) return 4;
    if (len == 0) return 5;
    if (e) begin
      sum = s ? len : acc + len;
      r = s ? pkt : pref;
      if (sum != r) return 6;
    end
    return 0;
  endfunction

  task automatic idleInputs();
    descValid = 0; descSop = 0; descEop = 0; descOwn = 0;
    descNext = '0; descBufPtr = '0; descBufLen = '0; descPktLen = '0;
    regWrEn = 0; regWrData = '0;
  endtask

  task automatic doReset();
    idleInputs(); regAddr = 2'd0;
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    mCode = 0; mInPkt = 0; mAcc = 0; mRef = 0; mHalt = 0; mMask = 0;
  endtask

  // one clock with the inputs already driven; model then checks
  task automatic cyc(string tag);
    bit newHalt;
    newHalt = mHalt || (mCode != 0);
    if (descValid) begin
      if (mCode == 0)
        mCode = refCode(mInPkt, mAcc, mRef, descSop, descEop, descOwn,
                        int'(descNext), int'(descBufPtr), int'(descBufLen), int'(descPktLen));
      if (descSop) begin mAcc = int'(descBufLen); mRef = int'(descPktLen); end
      else if (mInPkt != 0) mAcc = mAcc + int'(descBufLen);
      mInPkt = ((descSop || mInPkt != 0) && !descEop) ? 1 : 0;
    end
    if (regWrEn && regWrData[0]) begin
      if (regAddr == 2'd2) mMask = 1;
      else if (regAddr == 2'd3) mMask = 0;
    end
    mHalt = newHalt;
    @(posedge clk);
    @(negedge clk);
    idleInputs();
    chk({tag, " errCode"}, int'(errCode), mCode);
    chk("R10 haltReq", int'(haltReq), int'(mHalt));
    chk("R11 intMasked", int'(intMasked), int'(mCode != 0 && mMask));
  endtask

  task automatic desc(bit s, bit e, bit o, int nxt, int ptr, int len, int pkt);
    descValid = 1; descSop = s; descEop = e; descOwn = o;
    descNext = AW'(nxt); descBufPtr = AW'(ptr);
    descBufLen = LW'(len); descPktLen = LW'(pkt);
  endtask

  task automatic regWr(logic [1:0] a, logic [DW-1:0] d, string tag);
    regWrEn = 1; regAddr = a; regWrData = d;
    cyc(tag);
  endtask

  task automatic rdChk(logic [1:0] a, int exp, string tag);
    regAddr = a;
    #1;
    chk(tag, int'(regRdData), exp);
  endtask

  // one directed single-descriptor error after reset, literal expectation
  task automatic single(bit s, bit e, bit o, int nxt, int ptr, int len, int pkt,
                        int exp, string tag);
    doReset();
    desc(s, e, o, nxt, ptr, len, pkt);
    cyc(tag);
    chk(tag, int'(errCode), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    doReset();
    // R1 reset state
    chk("R1 errCode", int'(errCode), 0);
    chk("R1 intRaw", int'(intRaw), 0);
    chk("R1 intMasked", int'(intMasked), 0);
    chk("R1 haltReq", int'(haltReq), 0);
    rdChk(2'd2, 0, "R1 enable");

    // R2 framing: missing start, and start inside an open packet
    single(0, 1, 1, 0, 100, 4, 4, 1, "R2");
    doReset();
    desc(1, 0, 1, 64, 100, 4, 8); cyc("R2");
    desc(1, 1, 1, 0, 100, 4, 4);  cyc("R2");
    chk("R2 nested start", int'(errCode), 1);
    // R3 ownership, R4 chain, R5 pointer, R6 length
    single(1, 1, 0, 0, 100, 4, 4, 2, "R3");
    single(1, 0, 1, 0, 100, 4, 9, 3, "R4");
    single(1, 1, 1, 0, 0, 4, 4, 4, "R5");
    single(1, 1, 1, 0, 100, 0, 0, 5, "R6");
    // R7 good two-buffer packet, then mismatching one
    doReset();
    desc(1, 0, 1, 64, 100, 5, 9); cyc("R7");
    desc(0, 1, 1, 0, 200, 4, 0);  cyc("R7");
    chk("R7 good sum", int'(errCode), 0);
    desc(1, 0, 1, 64, 100, 5, 9); cyc("R7");
    desc(0, 1, 1, 0, 200, 3, 0);  cyc("R7");
    chk("R7 bad sum", int'(errCode), 6);
    // R8 priority and ignored idle cycles
    single(1, 0, 0, 0, 0, 0, 7, 2, "R8");
    doReset();
    descSop = 0; descBufPtr = '0; descValid = 0; cyc("R8");
    chk("R8 idle ignored", int'(errCode), 0);
    // R9 and R10 sticky first error and halt timing
    doReset();
    desc(1, 1, 1, 0, 0, 4, 4); cyc("R10");
    chk("R10 code visible", int'(errCode), 4);
    chk("R10 halt not yet", int'(haltReq), 0);
    desc(1, 1, 0, 0, 100, 4, 4); cyc("R9");
    chk("R9 first kept", int'(errCode), 4);
    chk("R10 halt raised", int'(haltReq), 1);
    // R11 mask set, clear, bit0 clear ignored
    regWr(2'd2, 8'hFE, "R11");
    chk("R11 no set", int'(intMasked), 0);
    regWr(2'd2, 8'h01, "R11");
    chk("R11 set", int'(intMasked), 1);
    regWr(2'd3, 8'hFE, "R11");
    chk("R11 no clear", int'(intMasked), 1);
    // R12 reads
    rdChk(2'd0, 1, "R12 raw");
    rdChk(2'd1, 1, "R12 masked");
    rdChk(2'd3, 1, "R12 enable");
    regWr(2'd3, 8'h01, "R11");
    rdChk(2'd1, 0, "R12 masked off");
    rdChk(2'd2, 0, "R12 enable off");

    // random packets with occasional faults
    for (int t = 0; t < 80; t++) begin
      doReset();
      if ($urandom_range(1, 0) == 1) regWr(2'd2, 8'h01, "R11");
      for (int p = 0; p < 6; p++) begin
        int n, total;
        int lens[4];
        n = $urandom_range(4, 1);
        total = 0;
        for (int k = 0; k < n; k++) begin
          lens[k] = $urandom_range(15, 1);
          total += lens[k];
        end
        for (int k = 0; k < n; k++) begin
          bit s, e, o;
          int nxt, ptr, len, pkt;
          s = (k == 0); e = (k == n - 1); o = 1;
          nxt = e ? 0 : 32'h1000 + 16 * k;
          ptr = 32'h8000 + 64 * k; len = lens[k]; pkt = total;
          if ($urandom_range(40, 0) == 0) s = ~s;
          if ($urandom_range(40, 0) == 0) o = 0;
          if ($urandom_range(40, 0) == 0) nxt = 0;
          if ($urandom_range(40, 0) == 0) ptr = 0;
          if ($urandom_range(40, 0) == 0) len = 0;
          if ($urandom_range(40, 0) == 0) pkt = pkt + 1;
          desc(s, e, o, nxt, ptr, len, pkt);
          cyc("R9");
          if ($urandom_range(3, 0) == 0) cyc("R8");
        end
      end
      rdChk(2'd0, int'(mCode != 0), "R12 raw");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule